// File: doc/BRIEF.md
# Mode-Multiplexed Address/Output Port

This block owns eight output pins that serve one of two masters, depending on the operating mode. In single-chip operation the pins show the contents of a software-written data latch. In expanded operation the same pins carry the low byte of the external bus address, and this byte follows the address in the same cycle. The choice is made again on every cycle from the mode input, so no reconfiguration step is needed.

Software reaches the block through a simple register slave. The slave has a select, a write strobe, an offset and 8-bit data. Writes at the data-register offset always land in the latch, whatever the mode. Reads at that offset return the levels sensed at the pin-driver inputs, registered for one cycle. They never return the latch contents.

A halt input can force every pin driver to high impedance. An option bit gates this: the halt takes effect only when the option bit is low. The tri-state path is combinational, and it overrides both the address drive and the latch drive.

Top module: `addr_out_port`

## Requirements
- R1: While rst_ni is low and after it is released, the latch is 0x00, so pin_o is 0x00 in single-chip mode (expanded_i = 0), and rd_data_o is 0x00.
- R2: In single-chip mode (expanded_i = 0), pin_o equals the data latch.
- R3: In expanded mode (expanded_i = 1), pin_o equals bus_addr_i[7:0] in the same cycle. Upper address bits have no effect on the pins.
- R4: A write (reg_sel_i = 1, reg_we_i = 1) at offset reg_addr_i = 0x1005 loads reg_wdata_i into the latch at the next rising clock edge. A write at any other offset, or with reg_sel_i = 0, leaves the latch unchanged.
- R5: A write in expanded mode does not disturb pin_o, which keeps showing the address. The written value appears on pin_o once expanded_i returns to 0.
- R6: When opt_nhalt_i = 0 and halt_ni = 0, pin_oe_o is 0x00 in the same cycle, in either mode.
- R7: When opt_nhalt_i = 1, or when halt_ni = 1, pin_oe_o is 0xFF. With opt_nhalt_i = 1, halt_ni has no effect.
- R8: A read (reg_sel_i = 1, reg_we_i = 0) at offset 0x1005 captures pin_i at the rising edge and presents it on rd_data_o after that edge. The value comes from pin_i, not from the latch.
- R9: After any rising edge without a read at offset 0x1005, rd_data_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register access select |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 16 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| expanded_i | input | 1 | 1 = expanded mode, 0 = single-chip mode |
| bus_addr_i | input | 16 | Current cycle address |
| halt_ni | input | 1 | Halt request, active low |
| opt_nhalt_i | input | 1 | Halt option bit; 0 lets the halt input tri-state the pins |
| pin_i | input | 8 | Sensed levels at the pin-driver inputs |
| pin_o | output | 8 | Pin drive values |
| pin_oe_o | output | 8 | Per-pin output enable, 1 = drive |

## Verification
The bench builds the block with its default parameters: an 8-bit port, a 16-bit bus address, a 16-bit register offset and the data register at 0x1005. With these values the bench drives addresses whose upper byte is non-zero, which shows that only the low byte reaches the pins. It also writes at the neighbouring offsets 0x1004 and 0x1006, and at 0x0005, whose low byte matches the data register. These writes show that the offset is decoded in full and that no alias exists.

// File: rtl/aop_pkg.sv
package aop_pkg;
  typedef enum logic {
    MODE_SINGLE   = 1'b0,
    MODE_EXPANDED = 1'b1
  } aop_mode_e;

  localparam int unsigned AOP_DATA_W     = 8;
  localparam int unsigned AOP_BUS_ADDR_W = 16;
  localparam int unsigned AOP_REG_ADDR_W = 16;
endpackage

// File: rtl/aop_reg.sv
module aop_reg #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned REG_ADDR_W = 16,
  parameter logic [REG_ADDR_W-1:0] REG_OFFSET = 16'h1005
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sel_i,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [DATA_W-1:0]     pin_i,
  output logic [DATA_W-1:0]     latch_o,
  output logic [DATA_W-1:0]     rdata_o
);
  logic hit, wr_en, rd_en;
  logic [DATA_W-1:0] latch_q, rdata_q;

  assign hit   = sel_i && (addr_i == REG_OFFSET);
  assign wr_en = hit && we_i;
  assign rd_en = hit && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    latch_q <= '0;
    else if (wr_en) latch_q <= wdata_i;
  end

  // read returns sensed pin level, never the latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= pin_i;
    else            rdata_q <= '0;
  end

  assign latch_o = latch_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/aop_halt_ctrl.sv
module aop_halt_ctrl (
  input  logic halt_ni,
  input  logic opt_nhalt_i,
  output logic tri_o
);
  assign tri_o = !opt_nhalt_i && !halt_ni;
endmodule

// File: rtl/aop_pin_mux.sv
module aop_pin_mux
  import aop_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  aop_mode_e         mode_i,
  input  logic [DATA_W-1:0] addr_lo_i,
  input  logic [DATA_W-1:0] latch_i,
  input  logic              tri_i,
  output logic [DATA_W-1:0] pin_o,
  output logic [DATA_W-1:0] pin_oe_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_pin
    always_comb begin
      unique case (mode_i)
        MODE_EXPANDED: pin_o[b] = addr_lo_i[b];
        default:       pin_o[b] = latch_i[b];
      endcase
      pin_oe_o[b] = !tri_i;
    end
  end
endmodule

// File: rtl/addr_out_port.sv
module addr_out_port
  import aop_pkg::*;
#(
  parameter int unsigned DATA_W     = AOP_DATA_W,
  parameter int unsigned BUS_ADDR_W = AOP_BUS_ADDR_W,
  parameter int unsigned REG_ADDR_W = AOP_REG_ADDR_W,
  parameter logic [REG_ADDR_W-1:0] REG_OFFSET = 16'h1005
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_sel_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic                  expanded_i,
  input  logic [BUS_ADDR_W-1:0] bus_addr_i,
  input  logic                  halt_ni,
  input  logic                  opt_nhalt_i,
  input  logic [DATA_W-1:0]     pin_i,
  output logic [DATA_W-1:0]     pin_o,
  output logic [DATA_W-1:0]     pin_oe_o
);
  localparam int unsigned HI_W = BUS_ADDR_W - DATA_W;

  logic [DATA_W-1:0] latch_q;
  logic              pin_tri;
  aop_mode_e         mode;
  logic              unused_addr_hi;

  assign mode           = aop_mode_e'(expanded_i);
  assign unused_addr_hi = ^bus_addr_i[BUS_ADDR_W-1 -: HI_W];

  aop_reg #(
    .DATA_W    (DATA_W),
    .REG_ADDR_W(REG_ADDR_W),
    .REG_OFFSET(REG_OFFSET)
  ) i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (reg_sel_i),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .pin_i  (pin_i),
    .latch_o(latch_q),
    .rdata_o(rd_data_o)
  );

  aop_halt_ctrl i_halt (
    .halt_ni    (halt_ni),
    .opt_nhalt_i(opt_nhalt_i),
    .tri_o      (pin_tri)
  );

  aop_pin_mux #(.DATA_W(DATA_W)) i_mux (
    .mode_i   (mode),
    .addr_lo_i(bus_addr_i[DATA_W-1:0]),
    .latch_i  (latch_q),
    .tri_i    (pin_tri),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );
endmodule

// File: rtl/addr_out_port_chk.sv
module addr_out_port_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BUS_ADDR_W = 16,
  parameter int unsigned REG_ADDR_W = 16,
  parameter logic [REG_ADDR_W-1:0] REG_OFFSET = 16'h1005
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_sel_i,
  input logic                  reg_we_i,
  input logic [REG_ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0]     reg_wdata_i,
  input logic [DATA_W-1:0]     rd_data_o,
  input logic                  expanded_i,
  input logic [BUS_ADDR_W-1:0] bus_addr_i,
  input logic                  halt_ni,
  input logic                  opt_nhalt_i,
  input logic [DATA_W-1:0]     pin_i,
  input logic [DATA_W-1:0]     pin_o,
  input logic [DATA_W-1:0]     pin_oe_o,
  input logic [DATA_W-1:0]     latch_i
);
  logic wr_hit, rd_hit;
  assign wr_hit = reg_sel_i && reg_we_i && (reg_addr_i == REG_OFFSET);
  assign rd_hit = reg_sel_i && !reg_we_i && (reg_addr_i == REG_OFFSET);

  p_sc_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expanded_i |-> pin_o == latch_i);
  p_exp_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expanded_i |-> pin_o == bus_addr_i[DATA_W-1:0]);
  p_write_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> latch_i == $past(reg_wdata_i));
  p_write_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(latch_i));
  p_halt_tri_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!opt_nhalt_i && !halt_ni) |-> pin_oe_o == '0);
  p_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opt_nhalt_i || halt_ni) |-> pin_oe_o == '1);
  p_read_pin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> rd_data_o == $past(pin_i));
  p_read_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> rd_data_o == '0);
endmodule

bind addr_out_port addr_out_port_chk #(
  .DATA_W    (DATA_W),
  .BUS_ADDR_W(BUS_ADDR_W),
  .REG_ADDR_W(REG_ADDR_W),
  .REG_OFFSET(REG_OFFSET)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_sel_i  (reg_sel_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .rd_data_o  (rd_data_o),
  .expanded_i (expanded_i),
  .bus_addr_i (bus_addr_i),
  .halt_ni    (halt_ni),
  .opt_nhalt_i(opt_nhalt_i),
  .pin_i      (pin_i),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o),
  .latch_i    (latch_q)
);

// File: tb/test_addr_out_port.sv
module test_addr_out_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] OFS = 16'h1005;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        expd = 1'b0;
  logic [15:0] baddr = '0;
  logic        halt_n = 1'b1, opt_nh = 1'b1;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_out_port i_addr_out_port (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .rd_data_o(rdata),
    .expanded_i(expd), .bus_addr_i(baddr), .halt_ni(halt_n),
    .opt_nhalt_i(opt_nh), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, logic s = 1'b1);
    @(negedge clk); sel = s; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 pins in reset", pin_out, 8'h00);
    chk("R1 rdata in reset", rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins after reset", pin_out, 8'h00);
    chk("R1 oe after reset", pin_oe, 8'hFF);
  endtask

  task automatic t_single_write;
    expd = 1'b0;
    wr(OFS, 8'hA5);
    chk("R2/R4 latch on pins", pin_out, 8'hA5);
    wr(OFS, 8'h3C);
    chk("R2/R4 second write", pin_out, 8'h3C);
  endtask

  task automatic t_ignored_writes;
    wr(16'h1004, 8'h11);
    chk("R4 offset 0x1004 ignored", pin_out, 8'h3C);
    wr(16'h1006, 8'h22);
    chk("R4 offset 0x1006 ignored", pin_out, 8'h3C);
    wr(16'h0005, 8'h33);
    chk("R4 alias 0x0005 ignored", pin_out, 8'h3C);
    wr(OFS, 8'h44, 1'b0);
    chk("R4 unselected write ignored", pin_out, 8'h3C);
  endtask

  task automatic t_expanded;
    @(negedge clk); expd = 1'b1; baddr = 16'hBE12; #1;
    chk("R3 low address byte", pin_out, 8'h12);
    baddr = 16'h0077; #1;
    chk("R3 address follows", pin_out, 8'h77);
    baddr = 16'hFF00; #1;
    chk("R3 upper bits ignored", pin_out, 8'h00);
  endtask

  task automatic t_exp_write_switch;
    baddr = 16'h5A69;
    wr(OFS, 8'hC3);
    chk("R5 address undisturbed", pin_out, 8'h69);
    @(negedge clk); expd = 1'b0; #1;
    chk("R5 latch after switch", pin_out, 8'hC3);
  endtask

  task automatic t_halt;
    @(negedge clk); opt_nh = 1'b0; halt_n = 1'b0; #1;
    chk("R6 tri in single-chip", pin_oe, 8'h00);
    expd = 1'b1; #1;
    chk("R6 tri in expanded", pin_oe, 8'h00);
    halt_n = 1'b1; #1;
    chk("R7 halt released", pin_oe, 8'hFF);
    expd = 1'b0;
  endtask

  task automatic t_halt_disabled;
    @(negedge clk); opt_nh = 1'b1; halt_n = 1'b0; #1;
    chk("R7 option set, halt ignored", pin_oe, 8'hFF);
    @(negedge clk); halt_n = 1'b1;
  endtask

  task automatic t_read;
    logic [7:0] d;
    pin_in = 8'h96;
    rd(OFS, d);
    chk("R8 read returns pin level", d, 8'h96);
    pin_in = 8'h00;
    rd(OFS, d);
    chk("R8 read not latch", d, 8'h00);
    @(negedge clk);
    chk("R9 idle rdata zero", rdata, 8'h00);
    pin_in = 8'hF0;
    rd(16'h1004, d);
    chk("R9 other offset reads zero", d, 8'h00);
  endtask

  initial begin
    t_reset();
    t_single_write();
    t_ignored_writes();
    t_expanded();
    t_exp_write_switch();
    t_halt();
    t_halt_disabled();
    t_read();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule